// File: doc/BRIEF.md
# Two-Thread Drafting Issue Stage

This block is the issue point of a two-thread, fine-grained multithreaded in-order core. In a normal cycle it picks one ready thread, taking turns between the two, and sends that thread's pending instruction word down the pipe with its thread number. When the surrounding control asks for a repeat, the block can instead issue the follower copy of the instruction it issued one cycle earlier. The follower copy goes out on the next cycle, tagged with the other thread's number. Decode and control downstream then see the same word a second time and do not toggle.

The block compares the leader's held word with the follower's pending word. If every bit matches, the pair is a full duplicate and the follower issues straight from the holding register. If only the opcode field matches, the pair is a partial duplicate: the follower issues its own word, still in the cycle right after the leader. If neither matches, the repeat request is dropped and normal turn-taking applies. The duplicate class goes out with the follower issue so that energy accounting can credit the stages that were saved. A divergence signal, a cleared enable, or a follower that is not ready also cancels the repeat for that cycle.

Top module: `draft_issue`

## Requirements
- R1: While reset is high, the cycle after each reset cycle shows no valid issue, the duplicate class 00 and the repeat flag 0.
- R2: Without a granted repeat, each cycle issues one ready thread. When both threads are ready, the thread other than the last one issued wins, and thread 0 is first after reset. When one thread is ready, it issues. When none is ready, nothing issues. All outputs are registered, one cycle after the inputs.
- R3: A granted repeat whose follower word equals the held leader word in all 32 bits issues the held word with the other thread's number, the repeat flag 1 and class 10 (full).
- R4: When the follower word differs from the held leader word but bits [31:30] and [24:19] match (mask 0xC1F80000), a granted repeat issues the follower's own word with the repeat flag 1 and class 01 (partial).
- R5: A repeat request whose words differ inside the opcode field is dropped. Normal selection applies and the class is 00.
- R6: A repeat request while the follower thread is not ready is dropped. Normal selection applies.
- R7: A repeat request in a cycle with the divergence input high is dropped. Normal selection applies.
- R8: With drafting disabled, repeat requests have no effect.
- R9: A follower issue only happens in the cycle right after a valid non-repeat issue. A second consecutive repeat request is dropped, and the holding register keeps the leader's word through a follower issue.
- R10: Every non-repeat issue reports class 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| draft_en | input | 1 | Enables repeat issue |
| repeat_req | input | 1 | Request to issue the follower copy this cycle |
| diverge | input | 1 | Threads diverged; cancels any repeat |
| thr_rdy | input | 2 | Per-thread ready flags, bit n for thread n |
| thr0_word | input | 32 | Pending instruction of thread 0 |
| thr1_word | input | 32 | Pending instruction of thread 1 |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_rpt | output | 1 | Issue is a follower (drafted) issue |
| iss_tid | output | 1 | Thread number of the issue |
| iss_word | output | 32 | Issued instruction word |
| iss_dup | output | 2 | Duplicate class: 00 none, 01 partial, 10 full |

## Verification
The bench separates the two duplicate classes. A design that always reissued the held word would send the leader's encoding on a partial match. A design that matched only the opcode field would report class 01 where 10 is due. Pairs that differ in one opcode bit check that a repeat is refused rather than drafted. The follower-not-ready, divergence and disabled cases each keep an otherwise valid repeat request from issuing a follower; a faulty design would issue for a thread that cannot accept it. Back-to-back repeat requests catch a design that lets a follower trail another follower.

// File: rtl/draft_pkg.sv
package draft_pkg;

    localparam int          WORD_W       = 32;
    localparam logic [31:0] OPC_MASK_DEF = 32'hC1F8_0000;

    typedef enum logic [1:0] {
        DUP_NONE = 2'b00,
        DUP_PART = 2'b01,
        DUP_FULL = 2'b10
    } dup_e;

    typedef struct packed {
        logic vld;
        logic rpt;
        logic tid;
        dup_e dup;
    } iss_ctl_t;

    // grade a pair from whole-word and opcode-field equality
    function automatic dup_e grade(input logic same_all, input logic same_opc);
        if (same_all)      return DUP_FULL;
        else if (same_opc) return DUP_PART;
        else               return DUP_NONE;
    endfunction

endpackage

// File: rtl/draft_dup_cmp.sv
module draft_dup_cmp
    import draft_pkg::*;
#(
    parameter int          W        = WORD_W,
    parameter logic [W-1:0] OPC_MASK = OPC_MASK_DEF
) (
    input  logic [W-1:0] lead_w,
    input  logic [W-1:0] cand_w,
    output dup_e         cls
);
    logic [W-1:0] diff;

    always_comb begin
        diff = lead_w ^ cand_w;
        cls  = grade(diff == '0, (diff & OPC_MASK) == '0);
    end
endmodule

// File: rtl/draft_rr_pick.sv
module draft_rr_pick (
    input  logic [1:0] rdy,
    input  logic       last_tid,
    output logic       pick_vld,
    output logic       pick_tid
);
    always_comb begin
        pick_vld = |rdy;
        unique case (rdy)
            2'b11:   pick_tid = ~last_tid;
            2'b10:   pick_tid = 1'b1;
            default: pick_tid = 1'b0;
        endcase
    end
endmodule

// File: rtl/draft_hold_reg.sv
module draft_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d_word,
    input  logic         d_tid,
    output logic [W-1:0] q_word,
    output logic         q_tid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_word <= '0;
            q_tid  <= 1'b0;
        end else if (load) begin
            q_word <= d_word;
            q_tid  <= d_tid;
        end
    end

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ($stable(q_word) && $stable(q_tid)));
endmodule

// File: rtl/draft_issue.sv
module draft_issue
    import draft_pkg::*;
#(
    parameter int          W        = WORD_W,
    parameter logic [W-1:0] OPC_MASK = OPC_MASK_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         draft_en,
    input  logic         repeat_req,
    input  logic         diverge,
    input  logic [1:0]   thr_rdy,
    input  logic [W-1:0] thr0_word,
    input  logic [W-1:0] thr1_word,
    output logic         iss_vld,
    output logic         iss_rpt,
    output logic         iss_tid,
    output logic [W-1:0] iss_word,
    output logic [1:0]   iss_dup
);
    localparam int NTHR = 2;

    logic [W-1:0] words [NTHR];
    assign words[0] = thr0_word;
    assign words[1] = thr1_word;

    iss_ctl_t     ctl_q, ctl_d;
    logic [W-1:0] word_q, word_d;
    logic         last_tid_q;

    logic [W-1:0] hold_word;
    logic         hold_tid;
    logic         fol_tid;
    dup_e         cls;
    logic         lead_prev, take_rpt;
    logic         pick_vld, pick_tid;

    assign fol_tid   = ~hold_tid;
    assign lead_prev = ctl_q.vld & ~ctl_q.rpt;

    draft_dup_cmp #(.W(W), .OPC_MASK(OPC_MASK)) u_cmp (
        .lead_w (hold_word),
        .cand_w (words[fol_tid]),
        .cls    (cls)
    );

    draft_rr_pick u_pick (
        .rdy      (thr_rdy),
        .last_tid (last_tid_q),
        .pick_vld (pick_vld),
        .pick_tid (pick_tid)
    );

    always_comb begin
        take_rpt = draft_en & repeat_req & ~diverge & lead_prev
                 & thr_rdy[fol_tid] & (cls != DUP_NONE);
        if (take_rpt) begin
            ctl_d  = '{vld: 1'b1, rpt: 1'b1, tid: fol_tid, dup: cls};
            word_d = (cls == DUP_FULL) ? hold_word : words[fol_tid];
        end else begin
            ctl_d  = '{vld: pick_vld, rpt: 1'b0, tid: pick_tid, dup: DUP_NONE};
            word_d = pick_vld ? words[pick_tid] : '0;
        end
    end

    // holding register loads on leader (non-repeat) issues only
    draft_hold_reg #(.W(W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl_d.vld & ~ctl_d.rpt),
        .d_word (word_d),
        .d_tid  (ctl_d.tid),
        .q_word (hold_word),
        .q_tid  (hold_tid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '{vld: 1'b0, rpt: 1'b0, tid: 1'b0, dup: DUP_NONE};
            word_q     <= '0;
            last_tid_q <= 1'b1;
        end else begin
            ctl_q  <= ctl_d;
            word_q <= word_d;
            if (ctl_d.vld) last_tid_q <= ctl_d.tid;
        end
    end

    assign iss_vld  = ctl_q.vld;
    assign iss_rpt  = ctl_q.rpt;
    assign iss_tid  = ctl_q.tid;
    assign iss_word = word_q;
    assign iss_dup  = ctl_q.dup;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!iss_vld && iss_dup == 2'b00 && !iss_rpt));

    // R3
    full_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_rpt && iss_dup == 2'b10) |->
            (iss_word == $past(iss_word) && iss_tid != $past(iss_tid)));

    // R4
    partial_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_rpt && iss_dup == 2'b01) |->
            ((((iss_word ^ $past(iss_word)) & OPC_MASK) == '0)
             && iss_word != $past(iss_word)));

    // R7
    diverge_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $past(diverge) |-> !iss_rpt);

    // R8
    draft_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(draft_en) |-> !iss_rpt);

    // R9
    lead_first_chk: assert property (@(posedge clk) disable iff (rst)
        iss_rpt |-> ($past(iss_vld) && !$past(iss_rpt)));

    // R10
    class_on_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_rpt |-> iss_dup == 2'b00);
endmodule

// File: tb/sim_draft_issue.sv
module sim_draft_issue;

    localparam logic [31:0] MASK = 32'hC1F8_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        draft_en = 1'b0, repeat_req = 1'b0, diverge = 1'b0;
    logic [1:0]  thr_rdy = 2'b00;
    logic [31:0] thr0_word = '0, thr1_word = '0;
    logic        iss_vld, iss_rpt, iss_tid;
    logic [31:0] iss_word;
    logic [1:0]  iss_dup;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    draft_issue u0 (
        .clk(clk), .rst(rst), .draft_en(draft_en), .repeat_req(repeat_req),
        .diverge(diverge), .thr_rdy(thr_rdy), .thr0_word(thr0_word),
        .thr1_word(thr1_word), .iss_vld(iss_vld), .iss_rpt(iss_rpt),
        .iss_tid(iss_tid), .iss_word(iss_word), .iss_dup(iss_dup)
    );

    typedef struct {
        bit          vld;
        bit          rpt;
        bit          tid;
        logic [1:0]  dup;
        logic [31:0] word;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // reference state
    bit          m_vld = 0, m_rpt = 0, m_tid = 0, m_last = 1;
    logic [31:0] m_word = '0;

    task automatic step(input logic [1:0] rdy, input logic [31:0] a, input logic [31:0] b,
                        input bit rep, input bit den, input bit div, input string tag);
        exp_t        e;
        bit          fol, full, part;
        logic [31:0] fw;
        @(negedge clk);
        thr_rdy = rdy; thr0_word = a; thr1_word = b;
        repeat_req = rep; draft_en = den; diverge = div;
        fol  = ~m_tid;
        fw   = fol ? b : a;
        full = (m_word == fw);
        part = !full && (((m_word ^ fw) & MASK) == 0);
        e.tag = tag;
        if (rep && den && !div && m_vld && !m_rpt && rdy[fol] && (full || part)) begin
            e.vld = 1; e.rpt = 1; e.tid = fol;
            e.dup = full ? 2'b10 : 2'b01;
            e.word = full ? m_word : fw;
        end else begin
            e.rpt = 0; e.dup = 2'b00;
            e.vld = (rdy != 2'b00);
            e.tid = (rdy == 2'b11) ? ~m_last : (rdy == 2'b10);
            e.word = e.vld ? (e.tid ? b : a) : '0;
        end
        sb.push_back(e);
        m_vld = e.vld; m_rpt = e.rpt; m_word = e.word;
        if (e.vld) begin m_tid = e.tid; m_last = e.tid; end
    endtask

    // monitor: compare one expected item per clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (iss_vld !== e.vld || iss_rpt !== e.rpt || iss_dup !== e.dup ||
                    (e.vld && (iss_tid !== e.tid || iss_word !== e.word))) begin
                    n_fail++;
                    $display("FAIL %s: got vld=%0b rpt=%0b tid=%0b dup=%b word=%h, exp vld=%0b rpt=%0b tid=%0b dup=%b word=%h",
                             e.tag, iss_vld, iss_rpt, iss_tid, iss_dup, iss_word,
                             e.vld, e.rpt, e.tid, e.dup, e.word);
                end
            end
        end
    end

    initial begin
        logic [31:0] wa, wp, wn, wb;
        wa = 32'h8A10_0005;
        wp = wa ^ 32'h0000_3F00;
        wn = wa ^ 32'h4000_0000;
        wb = 32'h1234_5678;
        thr_rdy = 2'b11; thr0_word = wa; thr1_word = wb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (iss_vld !== 1'b0 || iss_dup !== 2'b00 || iss_rpt !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got vld=%0b dup=%b rpt=%0b, exp 0 00 0", iss_vld, iss_dup, iss_rpt);
        end
        rst = 1'b0; thr_rdy = 2'b00;
        // R2 turn-taking, single ready, idle
        step(2'b11, wa, wb, 0, 1, 0, "R2 first");
        step(2'b11, wa, wb, 0, 1, 0, "R2 alternate");
        step(2'b11, wb, wa, 0, 1, 0, "R2 alternate");
        step(2'b10, wa, wb, 0, 1, 0, "R2 only t1");
        step(2'b10, wa, wb, 0, 1, 0, "R2 only t1 again");
        step(2'b01, wa, wb, 0, 1, 0, "R2 only t0");
        step(2'b00, wa, wb, 0, 1, 0, "R2 idle");
        // R3 full duplicate
        step(2'b11, wa, wa, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wa, 1, 1, 0, "R3 full");
        // R4 partial duplicate
        step(2'b11, wa, wp, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wp, 1, 1, 0, "R4 partial");
        // R5 non-duplicate
        step(2'b11, wa, wn, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wn, 1, 1, 0, "R5 none");
        // R6 follower not ready
        step(2'b11, wa, wa, 0, 1, 0, "R10 leader");
        step(2'b10, wa, wa, 1, 1, 0, "R6 follower idle");
        // R7 divergence
        step(2'b11, wa, wa, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wa, 1, 1, 1, "R7 diverge");
        // R8 drafting off
        step(2'b11, wa, wa, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wa, 1, 0, 0, "R8 disabled");
        // R9 back-to-back repeats, hold kept through follower
        step(2'b11, wa, wa, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wa, 1, 1, 0, "R9 first follower");
        step(2'b11, wa, wa, 1, 1, 0, "R9 second repeat dropped");
        step(2'b11, wb, wp, 0, 1, 0, "R10 leader");
        step(2'b11, wa, wp, 1, 1, 0, "R9 partial follower");
        step(2'b11, wp, wb, 1, 1, 0, "R9 after partial dropped");
        step(2'b00, wa, wb, 0, 1, 0, "R2 idle end");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got hung run, exp completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule